// File: doc/BRIEF.md
# Stack and Interrupt-Entry Sequencer

This block carries out every stack transfer and vector fetch of a small 8-bit processor core. The instruction decoder asks for one of eight operations (subroutine call, subroutine return, software break, return from interrupt, and the four single-byte push and pull operations). The sequencer then drives a byte-wide memory port with one access per clock until the operation finishes. It owns the 8-bit stack pointer, which addresses a stack held in memory page 0x01. It takes the program counter, accumulator, status byte and call target as inputs, and it hands back new values for them together with one-cycle load strobes.

After reset is released, the block runs its own start-up sequence. That sequence fetches the start address from the reset vector, lowers the stack pointer by three without writing to memory, and returns a status byte with the break and always-one bits set. Operation inputs are captured when a request is accepted, and a request made while the block is busy is dropped. The core therefore only needs to raise `start` when `busy` is low.

Top module: `stk_seq`

## Requirements
- R1: A stack byte sits at address 0x0100 + sp (the pointer wraps modulo 256). A push writes at sp and then leaves sp one lower. A pull reads at 0x0100 + ((sp+1) mod 256) and leaves sp one higher.
- R2: A 16-bit value is pushed high byte first and then low byte. It is pulled low byte first and then high byte.
- R3: Op code 0 (call) pushes pc_in minus 1 and loads pc_out with tgt_in. It takes two memory accesses.
- R4: Op code 1 (return) pulls a 16-bit value and loads pc_out with that value plus 1. It takes two accesses.
- R5: Op code 2 (break) pushes pc_in plus 1 and then pushes flags_in with bits 4 and 5 set. It reads the new PC low byte from 0xFFFE and the high byte from 0xFFFF. It returns flags_in with bit 2 set and takes five accesses.
- R6: Op code 3 (return from interrupt) pulls the status first, which is returned with bit 4 cleared and all other bits as pulled. It then pulls the 16-bit PC, which is loaded without adjustment. It takes three accesses.
- R7: Op code 4 pushes acc_in. Op code 5 pushes flags_in with bits 4 and 5 forced to 1.
- R8: Op code 6 loads acc_out with the pulled byte. It returns flags_in with bit 1 set exactly when that byte is zero, bit 7 copied from the byte's bit 7, and all other bits unchanged.
- R9: Op code 7 returns the pulled byte with bits 4 and 5 forced to 1 as the new status.
- R10: After reset release, the block reads 0xFFFC (low byte) and 0xFFFD (high byte) and loads that address into pc_out. It sets sp to SP_INIT minus 3 and returns flags_in with bits 4 and 5 set. It makes no write.
- R11: At most one memory access happens per clock. busy is high from the first access through the done cycle. done lasts one cycle and busy is low in the cycle after it. pc_load, acc_load and flags_load pulse only in the done cycle, and only for the operations that produce that value.
- R12: A start request made while busy is high, including during the done cycle and the reset sequence, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation (accepted when busy is low) |
| op | input | 3 | Operation code, see R3 to R9 |
| pc_in | input | 16 | Program counter value for call and break |
| tgt_in | input | 16 | Call target address |
| acc_in | input | 8 | Accumulator to push |
| flags_in | input | 8 | Current status byte |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last cycle of a sequence |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | pc_out is valid |
| acc_out | output | 8 | New accumulator |
| acc_load | output | 1 | acc_out is valid |
| flags_out | output | 8 | New status byte |
| flags_load | output | 1 | flags_out is valid |
| sp | output | 8 | Stack pointer |

## Verification
The two events that can share a cycle are the finishing access of one sequence and a new request. The bench holds start high with a push request for the whole of a call, including its done cycle. It also holds start high across the reset start-up sequence. It then judges the result from the stack pointer, from the stack byte that the stray push would have overwritten, and from busy being low after done. Stack-pointer wrap through 0x00 is provoked by a run of pulls followed by a push, and it is judged by which stack bytes are read and written.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int STW = 3;

  localparam logic [DW-1:0] STK_PAGE = 8'h01;
  localparam logic [AW-1:0] VEC_RST  = 16'hFFFC;
  localparam logic [AW-1:0] VEC_BRK  = 16'hFFFE;

  localparam int FL_Z   = 1;
  localparam int FL_I   = 2;
  localparam int FL_BRK = 4;
  localparam int FL_ONE = 5;
  localparam int FL_N   = 7;

  typedef enum logic [3:0] {
    SQ_CALL = 4'd0, SQ_RET  = 4'd1, SQ_BRK  = 4'd2, SQ_RTI  = 4'd3,
    SQ_PSHA = 4'd4, SQ_PSHF = 4'd5, SQ_PULA = 4'd6, SQ_PULF = 4'd7,
    SQ_RST  = 4'd8
  } seq_e;

  typedef enum logic [1:0] {AC_NONE, AC_PUSH, AC_PULL, AC_VEC} acc_e;

  function automatic logic [STW-1:0] seq_len(seq_e s);
    case (s)
      SQ_CALL, SQ_RET, SQ_RST: seq_len = 3'd2;
      SQ_BRK:                  seq_len = 3'd5;
      SQ_RTI:                  seq_len = 3'd3;
      default:                 seq_len = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/stk_rst_sync.sv
`timescale 1ns/1ps
module stk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/stk_ctrl.sv
`timescale 1ns/1ps
module stk_ctrl
  import stk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op_in,
  output seq_e           seq_q,
  output logic [STW-1:0] step_q,
  output logic           busy,
  output logic           last
);
  seq_e           seq_d;
  logic [STW-1:0] step_d;
  logic           busy_q, busy_d, adv;

  assign last = busy_q && (step_q == seq_len(seq_q) - 3'd1);
  assign adv  = busy_q || start;

  always_comb begin
    seq_d  = seq_q;
    step_d = step_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        step_d = '0;
      end else begin
        step_d = step_q + 3'd1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      seq_d  = seq_e'({1'b0, op_in});
      step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      seq_q  <= SQ_RST;
      step_q <= '0;
    end else if (adv) begin
      busy_q <= busy_d;
      seq_q  <= seq_d;
      step_q <= step_d;
    end
  end

  assign busy = busy_q;

  // R12: a running sequence keeps its operation until it finishes
  p_seq_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (seq_q == $past(seq_q)));
  // R11: the cycle after the last step is idle
  p_last_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);
endmodule

// File: rtl/stk_sp.sv
`timescale 1ns/1ps
module stk_sp
  import stk_pkg::*;
#(
  parameter logic [DW-1:0] SP_INIT = 8'h00,
  parameter int            DROP    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec1,
  input  logic          inc1,
  input  logic          drop,
  output logic [DW-1:0] sp
);
  localparam logic [DW-1:0] DROP_V = DW'(DROP);
  logic [DW-1:0] sp_q, sp_d;
  logic          en;

  assign en = dec1 || inc1 || drop;

  always_comb begin
    sp_d = sp_q;
    if (dec1)      sp_d = sp_q - 8'd1;
    else if (inc1) sp_d = sp_q + 8'd1;
    else if (drop) sp_d = sp_q - DROP_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sp_q <= SP_INIT;
    else if (en) sp_q <= sp_d;
  end

  assign sp = sp_q;

  // R11: the pointer moves at most one way per cycle
  p_sp_one_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec1, inc1, drop}));
endmodule

// File: rtl/stk_flagfix.sv
`timescale 1ns/1ps
module stk_flagfix
  import stk_pkg::*;
(
  input  seq_e          sel,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] pulled,
  output logic [DW-1:0] push_img,
  output logic [DW-1:0] result
);
  localparam logic [DW-1:0] M_BRK = DW'(1) << FL_BRK;
  localparam logic [DW-1:0] M_ONE = DW'(1) << FL_ONE;
  localparam logic [DW-1:0] M_I   = DW'(1) << FL_I;

  assign push_img = base | M_BRK | M_ONE;

  always_comb begin
    result = base;
    case (sel)
      SQ_BRK:  result = base | M_I;
      SQ_RTI:  result = pulled & ~M_BRK;
      SQ_PULF: result = pulled | M_BRK | M_ONE;
      SQ_RST:  result = base | M_BRK | M_ONE;
      SQ_PULA: begin
        result[FL_Z] = (pulled == '0);
        result[FL_N] = pulled[DW-1];
      end
      default: result = base;
    endcase
  end
endmodule

// File: rtl/stk_seq.sv
`timescale 1ns/1ps
module stk_seq
  import stk_pkg::*;
#(
  parameter logic [7:0] SP_INIT = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [15:0] pc_in,
  input  logic [15:0] tgt_in,
  input  logic [7:0]  acc_in,
  input  logic [7:0]  flags_in,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic        pc_load,
  output logic [7:0]  acc_out,
  output logic        acc_load,
  output logic [7:0]  flags_out,
  output logic        flags_load
  ,output logic [7:0] sp
);
  logic           rst_ni;
  seq_e           seq_q;
  logic [STW-1:0] step_q;
  logic           cap_en, lo_en, sf_en;
  logic [AW-1:0]  pc_q, tgt_q, ret_val, vaddr;
  logic [DW-1:0]  acc_q, flags_q, lo_q, sflag_q;
  logic [DW-1:0]  push_img, fl_base, fl_pulled, wbyte;
  acc_e           kind;

  stk_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  stk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_ni), .start(start), .op_in(op),
    .seq_q(seq_q), .step_q(step_q), .busy(busy), .last(done)
  );

  stk_sp #(.SP_INIT(SP_INIT), .DROP(3)) u_sp (
    .clk(clk), .rst_n(rst_ni),
    .dec1(mem_we),
    .inc1(busy && (kind == AC_PULL)),
    .drop(done && (seq_q == SQ_RST)),
    .sp(sp)
  );

  assign fl_base   = (seq_q == SQ_RST) ? flags_in : flags_q;
  assign fl_pulled = (seq_q == SQ_RTI) ? sflag_q : mem_rdata;

  stk_flagfix u_flag (
    .sel(seq_q), .base(fl_base), .pulled(fl_pulled),
    .push_img(push_img), .result(flags_out)
  );

  // operand capture at acceptance, byte capture on reads
  assign cap_en = !busy && start;
  assign sf_en  = mem_re && (seq_q == SQ_RTI) && (step_q == '0);
  assign lo_en  = mem_re && !sf_en;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      tgt_q   <= '0;
      acc_q   <= '0;
      flags_q <= '0;
    end else if (cap_en) begin
      pc_q    <= pc_in;
      tgt_q   <= tgt_in;
      acc_q   <= acc_in;
      flags_q <= flags_in;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    lo_q <= '0;
    else if (lo_en) lo_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    sflag_q <= '0;
    else if (sf_en) sflag_q <= mem_rdata;
  end

  // per-step access decode
  assign ret_val = (seq_q == SQ_BRK) ? pc_q + 16'd1 : pc_q - 16'd1;

  always_comb begin
    kind  = AC_NONE;
    wbyte = '0;
    vaddr = '0;
    case (seq_q)
      SQ_CALL: begin
        kind  = AC_PUSH;
        wbyte = (step_q == '0) ? ret_val[15:8] : ret_val[7:0];
      end
      SQ_BRK: begin
        if (step_q < 3'd3) begin
          kind = AC_PUSH;
          case (step_q)
            3'd0:    wbyte = ret_val[15:8];
            3'd1:    wbyte = ret_val[7:0];
            default: wbyte = push_img;
          endcase
        end else begin
          kind  = AC_VEC;
          vaddr = VEC_BRK + {13'd0, step_q - 3'd3};
        end
      end
      SQ_PSHA: begin kind = AC_PUSH; wbyte = acc_q; end
      SQ_PSHF: begin kind = AC_PUSH; wbyte = push_img; end
      SQ_RET, SQ_RTI, SQ_PULA, SQ_PULF: kind = AC_PULL;
      SQ_RST: begin
        kind  = AC_VEC;
        vaddr = VEC_RST + {13'd0, step_q};
      end
      default: kind = AC_NONE;
    endcase
  end

  always_comb begin
    case (kind)
      AC_PUSH: mem_addr = {STK_PAGE, sp};
      AC_PULL: mem_addr = {STK_PAGE, sp + 8'd1};
      default: mem_addr = vaddr;
    endcase
  end

  assign mem_wdata = wbyte;
  assign mem_we    = busy && (kind == AC_PUSH);
  assign mem_re    = busy && ((kind == AC_PULL) || (kind == AC_VEC));

  // results
  always_comb begin
    case (seq_q)
      SQ_CALL: pc_out = tgt_q;
      SQ_RET:  pc_out = {mem_rdata, lo_q} + 16'd1;
      default: pc_out = {mem_rdata, lo_q};
    endcase
  end

  assign acc_out    = mem_rdata;
  assign pc_load    = done && ((seq_q == SQ_CALL) || (seq_q == SQ_RET) ||
                               (seq_q == SQ_BRK)  || (seq_q == SQ_RTI) ||
                               (seq_q == SQ_RST));
  assign acc_load   = done && (seq_q == SQ_PULA);
  assign flags_load = done && ((seq_q == SQ_BRK)  || (seq_q == SQ_RTI) ||
                               (seq_q == SQ_PULA) || (seq_q == SQ_PULF) ||
                               (seq_q == SQ_RST));

  // R1: writes land in the stack page at the pointer
  p_push_page_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |-> (mem_addr == {8'h01, sp}));
  // R1: pointer drops by one after each write
  p_push_dec_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |=> (sp == $past(sp) - 8'd1));
  // R1: pointer rises by one after each stack read
  p_pull_inc_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_re && (mem_addr[15:8] == 8'h01)) |=> (sp == $past(sp) + 8'd1));
  // R11: one access per clock
  p_one_access_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !(mem_we && mem_re));
  // R11: result strobes only in the done cycle
  p_load_in_done_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (pc_load || acc_load || flags_load) |-> (done && busy));
  // R10: start-up sequence never writes
  p_rst_no_write_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && (seq_q == SQ_RST)) |-> !mem_we);
endmodule

// File: tb/stk_seq_bench.sv
`timescale 1ns/1ps
module stk_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [15:0] pc_in, tgt_in;
  logic [7:0]  acc_in, flags_in;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, mem_re, busy, done;
  logic [15:0] pc_out;
  logic        pc_load, acc_load, flags_load;
  logic [7:0]  acc_out, flags_out, sp;

  logic [7:0]  pg [256];
  logic [15:0] v_rst = 16'hC0DE;
  logic [15:0] v_brk = 16'h9ABC;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] r_pc;
  logic [7:0]  r_acc, r_fl, r_sp;
  logic        r_pcl, r_accl, r_fll, r_busy;
  int          r_acc_n;

  always #2 clk = ~clk;

  stk_seq u_stk_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .pc_in(pc_in), .tgt_in(tgt_in), .acc_in(acc_in), .flags_in(flags_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .pc_out(pc_out), .pc_load(pc_load), .acc_out(acc_out),
    .acc_load(acc_load), .flags_out(flags_out), .flags_load(flags_load),
    .sp(sp)
  );

  always_comb begin
    if (mem_addr[15:8] == 8'h01)   mem_rdata = pg[mem_addr[7:0]];
    else if (mem_addr == 16'hFFFC) mem_rdata = v_rst[7:0];
    else if (mem_addr == 16'hFFFD) mem_rdata = v_rst[15:8];
    else if (mem_addr == 16'hFFFE) mem_rdata = v_brk[7:0];
    else if (mem_addr == 16'hFFFF) mem_rdata = v_brk[15:8];
    else                           mem_rdata = 8'hEE;
  end

  always @(posedge clk) begin
    if (mem_we && mem_addr[15:8] == 8'h01) pg[mem_addr[7:0]] <= mem_wdata;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one operation; records results from the done cycle and sp afterwards
  task automatic run_op(input logic [2:0] o, input logic [15:0] p, input logic [15:0] t,
                        input logic [7:0] a, input logic [7:0] f);
    @(negedge clk);
    op = o; pc_in = p; tgt_in = t; acc_in = a; flags_in = f; start = 1'b1;
    r_acc_n = 0;
    r_pcl = 1'b0; r_accl = 1'b0; r_fll = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (mem_we || mem_re) r_acc_n++;
      if (done) begin
        r_pc = pc_out; r_pcl = pc_load; r_acc = acc_out; r_accl = acc_load;
        r_fl = flags_out; r_fll = flags_load;
        break;
      end
    end
    @(negedge clk);
    r_sp = sp; r_busy = busy;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b1; op = 3'd4; acc_in = 8'h66;
    flags_in = 8'h01; pc_in = '0; tgt_in = '0;
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", busy, 1);
    chk("R10 no write in reset", mem_we, 0);
    chk("R10 sp reset", sp, 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R10 no write", mem_we, 0);
      if (done) break;
    end
    chk("R10 pc", pc_out, 16'hC0DE);
    chk("R10 pc_load", pc_load, 1);
    chk("R10 flags", flags_out, 8'h31);
    chk("R10 flags_load", flags_load, 1);
    chk("R11 no acc_load", acc_load, 0);
    @(negedge clk);
    start = 1'b0;
    chk("R12 start ignored in reset", busy, 0);
    chk("R10 sp drop", sp, 8'hFD);
  endtask

  task automatic t_call_ret();
    run_op(3'd0, 16'h1234, 16'h4000, 8'h00, 8'h00);
    chk("R3 pc", r_pc, 16'h4000);
    chk("R3 pc_load", r_pcl, 1);
    chk("R3 no flags_load", r_fll, 0);
    chk("R3 accesses", r_acc_n, 2);
    chk("R2 high byte first", pg[8'hFD], 8'h12);
    chk("R2 low byte second", pg[8'hFC], 8'h33);
    chk("R1 sp after call", r_sp, 8'hFB);
    chk("R11 idle after done", r_busy, 0);
    run_op(3'd1, 16'h0, 16'h0, 8'h00, 8'h00);
    chk("R4 pc plus one", r_pc, 16'h1234);
    chk("R4 accesses", r_acc_n, 2);
    chk("R1 sp after return", r_sp, 8'hFD);
  endtask

  task automatic t_brk_rti();
    run_op(3'd2, 16'h2000, 16'h0, 8'h00, 8'h81);
    chk("R5 ret hi", pg[8'hFD], 8'h20);
    chk("R5 ret lo", pg[8'hFC], 8'h01);
    chk("R5 stacked status", pg[8'hFB], 8'hB1);
    chk("R5 pc vector", r_pc, 16'h9ABC);
    chk("R5 flags I set", r_fl, 8'h85);
    chk("R5 flags_load", r_fll, 1);
    chk("R5 accesses", r_acc_n, 5);
    chk("R5 sp", r_sp, 8'hFA);
    pg[8'hFB] = 8'hFF;
    run_op(3'd3, 16'h0, 16'h0, 8'h00, 8'h00);
    chk("R6 status bit4 cleared", r_fl, 8'hEF);
    chk("R6 pc unadjusted", r_pc, 16'h2001);
    chk("R6 accesses", r_acc_n, 3);
    chk("R6 sp", r_sp, 8'hFD);
  endtask

  task automatic t_push_pull();
    run_op(3'd4, 16'h0, 16'h0, 8'h7E, 8'h00);
    chk("R7 push acc", pg[8'hFD], 8'h7E);
    chk("R7 no loads", {r_pcl, r_accl, r_fll}, 3'b000);
    run_op(3'd5, 16'h0, 16'h0, 8'h00, 8'hC3);
    chk("R7 push status forced", pg[8'hFC], 8'hF3);
    chk("R7 sp", r_sp, 8'hFB);
    pg[8'hFC] = 8'h02;
    run_op(3'd7, 16'h0, 16'h0, 8'h00, 8'hFF);
    chk("R9 pulled status forced", r_fl, 8'h32);
    chk("R9 flags_load", r_fll, 1);
    pg[8'hFD] = 8'h00;
    run_op(3'd6, 16'h0, 16'h0, 8'h00, 8'h41);
    chk("R8 acc zero", r_acc, 8'h00);
    chk("R8 acc_load", r_accl, 1);
    chk("R8 zero flag", r_fl, 8'h43);
    pg[8'hFE] = 8'h80;
    run_op(3'd6, 16'h0, 16'h0, 8'h00, 8'h02);
    chk("R8 negative flag", r_fl, 8'h80);
    chk("R8 acc neg", r_acc, 8'h80);
  endtask

  task automatic t_wrap();
    pg[8'hFF] = 8'h05;
    run_op(3'd6, 16'h0, 16'h0, 8'h00, 8'h82);
    chk("R8 positive nonzero", r_fl, 8'h00);
    chk("R1 sp ff", r_sp, 8'hFF);
    pg[8'h00] = 8'h33;
    run_op(3'd6, 16'h0, 16'h0, 8'h00, 8'h00);
    chk("R1 wrap read", r_acc, 8'h33);
    chk("R1 wrap sp", r_sp, 8'h00);
    run_op(3'd4, 16'h0, 16'h0, 8'h99, 8'h00);
    chk("R1 write at 00", pg[8'h00], 8'h99);
    chk("R1 wrap down", r_sp, 8'hFF);
  endtask

  task automatic t_ignore();
    logic [7:0] sp0;
    sp0 = sp;
    pg[sp0 - 8'd2] = 8'h5A;
    @(negedge clk);
    op = 3'd0; pc_in = 16'h0101; tgt_in = 16'h0300; start = 1'b1;
    @(negedge clk);
    op = 3'd4; acc_in = 8'hA5;
    for (int i = 0; i < 20; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R12 call pc in overlap", pc_out, 16'h0300);
    @(negedge clk);
    start = 1'b0;
    chk("R12 not restarted", busy, 0);
    chk("R12 sp only call", sp, sp0 - 8'd2);
    chk("R12 byte untouched", pg[sp0 - 8'd2], 8'h5A);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pg[i] = 8'h00;
    t_reset();
    t_call_ret();
    t_brk_rti();
    t_push_pull();
    t_wrap();
    t_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule